// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a countdown watchdog on a small 32-bit register bus. Software picks a timeout with a 4-bit code, turns the counter on, and must then keep restarting it by writing a fixed key value. Code c selects a period of 2^(BASE_EXP+c) clock cycles. BASE_EXP is 16 by default, so there are sixteen periods from 2^16 to 2^31 cycles. A smaller BASE_EXP gives short runs in simulation. If the counter runs out before it is restarted, the block drives a reset pulse of fixed length and reloads itself.

The timeout register holds two codes:
- **Normal code:** used for every restart and for the reload after an expiry.
- **Initial code:** used only for the load when the watchdog is first turned on.

Once the watchdog is on, software cannot turn it off. Only the block reset clears the enable.

The counter is controlled by a state machine with three states:
- **WD_IDLE:** the watchdog is off and the count is held at zero.
- **WD_FIRST:** the first period after enabling, counted from the initial code.
- **WD_NORMAL:** every period after that, counted from the normal code.

The counter moves between them on these transitions:
- **arm:** WD_IDLE to WD_FIRST, on a control write with bit 0 set.
- **range_reload:** WD_FIRST to WD_FIRST, on a write to the timeout register.
- **kick:** WD_FIRST or WD_NORMAL to WD_NORMAL, on a key write.
- **expire:** WD_FIRST or WD_NORMAL to WD_NORMAL, when the count is zero.
- **count:** the state is held and the count drops by one.

A second machine shapes the reset output. PG_QUIET goes to PG_ACTIVE on a fire. PG_ACTIVE returns to PG_QUIET once PULSE_LEN cycles have elapsed. A new fire while PG_ACTIVE restarts the pulse.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, all of these read 0 and the reset output is low: the control word (offset 0x00), the timeout word (offset 0x04) and the count (offset 0x08).
- R2: Writing control with bit 0 = 1 turns the watchdog on. Reading offset 0x00 then returns 1 in bit 0 and 0 in all other bits.
- R3: While the watchdog is on, a control write with bit 0 = 0 leaves it on. Only the block reset turns it off.
- R4: A write to offset 0x04 stores the normal code from bits 3:0 and the initial code from bits 7:4. A read of offset 0x04 returns both codes in the same positions, with all upper bits 0.
- R5: When the watchdog is turned on, the counter loads 2^(BASE_EXP+initial code). While the watchdog is off, offset 0x08 reads 0.
- R6: Writing 0x76 to offset 0x0C while the watchdog is on reloads the counter with 2^(BASE_EXP+normal code).
- R7: These writes leave the counter to keep counting down: a write of any value other than 0x76 to offset 0x0C, and a key write while the watchdog is off.
- R8: During the first period, a write to offset 0x04 reloads the counter from the newly written initial code. After any reload from the normal code, a write to offset 0x04 does not reload the counter.
- R9: The counter decrements once per clock. On the clock edge that finds it at zero, it reloads from the normal code. On that same edge the reset output rises and stays high for exactly PULSE_LEN (8) cycles.
- R10: Writes to offsets other than 0x00, 0x04 and 0x0C change nothing. Reads of offset 0x0C or of any unmapped offset return 0.
- R11: With normal code 0, the reset output rises on the 2^BASE_EXP+1-th edge after a key write.
- R12: A key write on the same edge that finds the count at zero reloads the counter and does not raise the reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_rst_out | output | 1 | Reset request pulse, registered |

## Verification
The main function is tried with four patterns:
- **Enable then range write:** an enable followed by a range write within the first period shows whether the initial code is honoured and reloaded.
- **Wrong key, then correct key:** a wrong-key write followed by a correct key separates a real restart from plain counting down.
- **Range write after a kick:** shows that the initial-code reload is confined to the first period.
- **Unkicked runs:** runs left to expire, under a mid-range code and under code 0, pin the exact expiry edge and the pulse length.

A behavioural model in the bench predicts the read data and the reset output on every clock, whatever address is being presented.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_RANGE = 8'h04;
    localparam logic [7:0] OFS_COUNT = 8'h08;
    localparam logic [7:0] OFS_KICK  = 8'h0C;
    localparam logic [7:0] KICK_KEY  = 8'h76;

    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_FIRST  = 2'd1,
        WD_NORMAL = 2'd2
    } wd_state_t;

    typedef enum logic {
        PG_QUIET  = 1'b0,
        PG_ACTIVE = 1'b1
    } pg_state_t;

    typedef struct packed {
        logic arm;
        logic range_wr;
        logic kick;
    } wd_cmd_t;

endpackage

// File: rtl/keyed_wdt_loadval.sv
module keyed_wdt_loadval #(
    parameter int BASE_EXP = 16,
    parameter int CNT_W    = BASE_EXP + 16
) (
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        value = ONE << (BASE_EXP + int'(code));
    end
endmodule

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              en,
    input  logic [CNT_W-1:0]  cnt_q,
    output wd_cmd_t           cmd,
    output logic [3:0]        top_q,
    output logic [3:0]        init_q,
    output logic [3:0]        init_eff,
    output logic [31:0]       bus_rdata
);
    logic sel_ctrl, sel_range, sel_count, sel_kick;

    always_comb begin
        sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_range = (bus_addr == ADDR_W'(OFS_RANGE));
        sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
        sel_kick  = (bus_addr == ADDR_W'(OFS_KICK));
    end

    always_comb begin
        cmd.arm      = bus_we && sel_ctrl && bus_wdata[0];
        cmd.range_wr = bus_we && sel_range;
        cmd.kick     = bus_we && sel_kick && (bus_wdata == 32'(KICK_KEY));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q  <= 4'd0;
            init_q <= 4'd0;
        end else if (cmd.range_wr) begin
            top_q  <= bus_wdata[3:0];
            init_q <= bus_wdata[7:4];
        end
    end

    always_comb begin
        init_eff = cmd.range_wr ? bus_wdata[7:4] : init_q;
    end

    always_comb begin
        bus_rdata = 32'd0;
        if (sel_ctrl)       bus_rdata = {31'd0, en};
        else if (sel_range) bus_rdata = {24'd0, init_q, top_q};
        else if (sel_count) bus_rdata = 32'(cnt_q);
    end
endmodule

// File: rtl/keyed_wdt_fsm.sv
module keyed_wdt_fsm
    import keyed_wdt_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int CNT_W    = BASE_EXP + 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_cmd_t          cmd,
    input  logic [3:0]       top_q,
    input  logic [3:0]       init_eff,
    output logic             en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire
);
    wd_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] load_init, load_top;
    logic             at_zero;

    keyed_wdt_loadval #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_ld_init (
        .code (init_eff),
        .value(load_init)
    );

    keyed_wdt_loadval #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_ld_top (
        .code (top_q),
        .value(load_top)
    );

    assign at_zero = (cnt_q == '0);

    // next state and next count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            WD_IDLE: begin
                if (cmd.arm) begin          // arm
                    st_d  = WD_FIRST;
                    cnt_d = load_init;
                end
            end
            WD_FIRST: begin
                if (cmd.range_wr) begin     // range_reload
                    cnt_d = load_init;
                end else if (cmd.kick || at_zero) begin  // kick / expire
                    st_d  = WD_NORMAL;
                    cnt_d = load_top;
                end else begin              // count
                    cnt_d = cnt_q - 1'b1;
                end
            end
            WD_NORMAL: begin
                if (cmd.kick || at_zero) begin
                    cnt_d = load_top;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                st_d  = WD_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WD_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        en   = (st_q != WD_IDLE);
        fire = 1'b0;
        unique case (st_q)
            WD_FIRST:  fire = at_zero && !cmd.range_wr && !cmd.kick;
            WD_NORMAL: fire = at_zero && !cmd.kick;
            default:   fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/keyed_wdt_pulse.sv
module keyed_wdt_pulse
    import keyed_wdt_pkg::*;
#(
    parameter int PULSE_LEN = 8,
    localparam int PW       = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);
    localparam logic [PW-1:0] ONE = PW'(1);

    pg_state_t      st_q, st_d;
    logic [PW-1:0]  left_q, left_d;

    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        unique case (st_q)
            PG_QUIET: begin
                if (fire) begin
                    st_d   = PG_ACTIVE;
                    left_d = LEN;
                end
            end
            PG_ACTIVE: begin
                if (fire) begin
                    left_d = LEN;
                end else if (left_q == ONE) begin
                    st_d   = PG_QUIET;
                    left_d = '0;
                end else begin
                    left_d = left_q - ONE;
                end
            end
            default: begin
                st_d   = PG_QUIET;
                left_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PG_QUIET;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
        end
    end

    always_comb begin
        pulse = (st_q == PG_ACTIVE);
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_EXP  = 16,
    parameter int PULSE_LEN = 8,
    localparam int CNT_W    = BASE_EXP + 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sys_rst_out
);
    wd_cmd_t          cmd;
    logic [3:0]       top_q, init_q, init_eff;
    logic             en, fire, kick_stb;
    logic [CNT_W-1:0] cnt_q;

    assign kick_stb = cmd.kick;

    keyed_wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .en       (en),
        .cnt_q    (cnt_q),
        .cmd      (cmd),
        .top_q    (top_q),
        .init_q   (init_q),
        .init_eff (init_eff),
        .bus_rdata(bus_rdata)
    );

    keyed_wdt_fsm #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .top_q   (top_q),
        .init_eff(init_eff),
        .en      (en),
        .cnt_q   (cnt_q),
        .fire    (fire)
    );

    keyed_wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .pulse(sys_rst_out)
    );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
    parameter int BASE_EXP = 16,
    parameter int CNT_W    = BASE_EXP + 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             kick_stb,
    input logic [3:0]       top_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             sys_rst_out
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);

    a_r5_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cnt_q == '0));

    a_r6_kick_reloads_top: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_stb && en) |=> (cnt_q == (ONE << (BASE_EXP + int'($past(top_q))))));

    a_r9_pulse_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_out) |-> ($past(cnt_q) == '0 && $past(en)));

    a_r9_pulse_not_single: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_out) |=> sys_rst_out);
endmodule

bind keyed_wdt keyed_wdt_chk #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .kick_stb   (kick_stb),
    .top_q      (top_q),
    .cnt_q      (cnt_q),
    .sys_rst_out(sys_rst_out)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
    localparam int CLK_PERIOD = 10;
    localparam int B          = 4;
    localparam int PLEN       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h08;
    logic        we = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        rst_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // behavioural model state
    bit      m_en;
    bit      m_first;
    int      m_top, m_init, m_pulse;
    longint  m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdt #(.ADDR_W(8), .BASE_EXP(B), .PULSE_LEN(PLEN)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (addr),
        .bus_we     (we),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .sys_rst_out(rst_out)
    );

    function automatic longint pow2(input int e);
        return longint'(1) << e;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00:   return {31'd0, m_en};
            8'h04:   return 32'((m_init << 4) | m_top);
            8'h08:   return 32'(m_cnt);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit fire_now;
        fire_now = 1'b0;
        if (!rst_n) begin
            m_en = 0; m_first = 0; m_top = 0; m_init = 0; m_cnt = 0; m_pulse = 0;
        end else begin
            if (we && addr == 8'h00 && wdata[0] && !m_en) begin
                m_en = 1; m_first = 1; m_cnt = pow2(B + m_init);
            end else if (we && addr == 8'h04) begin
                m_top = int'(wdata[3:0]); m_init = int'(wdata[7:4]);
                if (m_en && m_first) m_cnt = pow2(B + m_init);
                else if (m_en) m_cnt = (m_cnt == 0) ? pow2(B + m_top) : m_cnt - 1;
                if (m_en && !m_first && m_cnt == pow2(B + m_top) && 1'b0) m_cnt = m_cnt;
            end else if (we && addr == 8'h0C && wdata == 32'h76 && m_en) begin
                m_cnt = pow2(B + m_top); m_first = 0;
            end else if (m_en) begin
                if (m_cnt == 0) begin
                    m_cnt = pow2(B + m_top); m_first = 0; fire_now = 1'b1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (fire_now) m_pulse = PLEN;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        check("R5 model read data", rdata, m_read(addr));
        check("R9 model reset output", {31'd0, rst_out}, {31'd0, (m_pulse > 0)});
    end

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk); #2;
        we = 1'b0; addr = 8'h08; wdata = 32'd0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a; #1; v = rdata;
    endtask

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #2;

        rd(8'h00, v); check("R1 ctrl after reset", v, 32'd0);
        rd(8'h04, v); check("R1 range after reset", v, 32'd0);
        rd(8'h08, v); check("R1 count after reset", v, 32'd0);
        check("R1 reset out low", {31'd0, rst_out}, 32'd0);

        wr(8'h04, 32'h0000_0012);
        rd(8'h04, v); check("R4 range readback", v, 32'h12);
        wr(8'h0C, 32'h76);
        rd(8'h08, v); check("R7 key while off", v, 32'd0);
        rd(8'h00, v); check("R5 still off", v, 32'd0);

        wr(8'h00, 32'h1);
        rd(8'h00, v); check("R2 enable readback", v, 32'd1);
        rd(8'h08, v); check("R5 initial load", v, 32'd32);

        wr(8'h04, 32'h0000_0022);
        rd(8'h08, v); check("R8 first-period range reload", v, 32'd64);

        wr(8'h0C, 32'h75);
        rd(8'h08, v); check("R7 wrong key ignored", v, 32'd62);

        wr(8'h0C, 32'h76);
        rd(8'h08, v); check("R6 key reload", v, 32'd64);

        wr(8'h04, 32'h0000_0031);
        rd(8'h08, v); check("R8 no reload after kick", v, 32'd62);
        rd(8'h04, v); check("R4 range readback 2", v, 32'h31);

        wr(8'h00, 32'h0);
        rd(8'h00, v); check("R3 disable ignored", v, 32'd1);

        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R10 unmapped read", v, 32'd0);
        rd(8'h0C, v); check("R10 restart reads zero", v, 32'd0);
        rd(8'h04, v); check("R10 range untouched", v, 32'h31);
        addr = 8'h08;

        while (!rst_out) @(negedge clk);
        #2;
        rd(8'h08, v); check("R9 reload on expiry", v, 32'd32);
        n = 0;
        while (rst_out) begin n++; @(negedge clk); end
        check("R9 pulse length", 32'(n), 32'(PLEN));
        #2;

        wr(8'h04, 32'h0000_0000);
        wr(8'h0C, 32'h76);
        rd(8'h08, v); check("R11 code 0 load", v, 32'd16);
        n = 0;
        while (!rst_out) begin @(negedge clk); n++; end
        check("R11 expiry edge", 32'(n), 32'd17);
        #2;
        repeat (12) @(negedge clk);
        #2;

        // R12: key on the edge that finds count zero
        wr(8'h0C, 32'h76);
        repeat (15) @(negedge clk);
        #2;
        rd(8'h08, v); check("R12 count before race", v, 32'd1);
        wr(8'h0C, 32'h76);
        rd(8'h08, v); check("R12 kick wins reload", v, 32'd16);
        check("R12 no pulse", {31'd0, rst_out}, 32'd0);
        @(negedge clk); #1;
        check("R12 still no pulse", {31'd0, rst_out}, 32'd0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule